// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic stage of a small 16-bit microcontroller core. It takes two operands, an operation code, a byte/word select and an incoming carry, and in the same cycle returns a result, next values for the overflow (V), negative (N), zero (Z) and carry (C) flags, a mask that tells the status register which of those flags to load, and a write-enable for the destination register.

One adder and one bitwise unit serve both widths. In byte mode only the low 8 operand bits take part. The result's upper byte is forced to zero. Carry, sign and overflow are taken at bit 7 instead of bit 15. Compare and bit-test are the flag-only forms of subtract and AND: they raise the flag mask but leave the write-enable low.

The block is purely combinational and has no clock or reset. The caller registers the result and the flags.

Top module: `bwalu_top`

## Requirements
- R1: ADD (opcode 0) returns A+B modulo the selected width. C is the carry out of the selected width's top bit. `wr_en`=1 and `flag_mask`=4'b1111.
- R2: ADDC (opcode 1) returns A+B+`carry_in`, with C defined as in R1.
- R3: SUB (opcode 2) returns A+~B+1 (that is, A−B). C=1 means no borrow, which is the case when A≥B as unsigned values.
- R4: SUBC (opcode 3) returns A+~B+`carry_in`, with C defined as in R3.
- R5: For opcodes 0–4, V=1 exactly when the true signed result does not fit the signed range of the selected width (−128..127 for bytes, −32768..32767 for words).
- R6: N equals the top bit of the selected width of the result. Z=1 exactly when that width of the result is zero.
- R7: With `byte_mode`=1, `result[15:8]` is zero and operand bits 15:8 have no effect on any output.
- R8: CMP (opcode 4) produces the same flags as SUB, with `wr_en`=0 and `flag_mask`=4'b1111.
- R9: AND (opcode 5) and XOR (opcode 7) return the bitwise result with V=0 and C=!Z, `wr_en`=1 and `flag_mask`=4'b1111.
- R10: OR (opcode 6) returns A|B with `wr_en`=1 and `flag_mask`=4'b0000, so no flag is loaded. The flag outputs still follow the logical rule V=0, C=!Z.
- R11: BIT (opcode 8) produces the flags of AND, with `wr_en`=0 and `flag_mask`=4'b1111.
- R12: Opcodes 9–15 give `result`=0, `wr_en`=0 and `flag_mask`=4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand (the A in A−B) |
| op_b | input | 16 | Second operand |
| opcode | input | 4 | Operation select, encoded as listed in the requirements |
| byte_mode | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit operation |
| carry_in | input | 1 | Current C flag, used by ADDC and SUBC |
| result | output | 16 | Operation result |
| flag_v | output | 1 | Next overflow flag |
| flag_n | output | 1 | Next negative flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| flag_mask | output | 4 | Flags to load: bit 3 V, bit 2 N, bit 1 Z, bit 0 C |
| wr_en | output | 1 | Write the result to the destination |

## Verification
The bench targets the edges where byte and word behaviour split. It sets a carry out of bit 7 under junk upper operand bits: a design that took C from bit 15 in byte mode would miss that carry. It also covers 0x7F+1 against 0x7FFF+1, where a design that tested overflow at the wrong width would report V falsely. Subtraction is driven with equal operands and with A<B, so a design that inverted the borrow sense would get C backwards. Compare, bit-test, OR and the unused opcodes are each checked for their write-enable and mask, which exposes a design that writes back a compare result or loads flags on OR.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;

    localparam int unsigned OPC_W  = 4;
    localparam int unsigned FLAG_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 4'd0,
        OPC_ADDC = 4'd1,
        OPC_SUB  = 4'd2,
        OPC_SUBC = 4'd3,
        OPC_CMP  = 4'd4,
        OPC_AND  = 4'd5,
        OPC_OR   = 4'd6,
        OPC_XOR  = 4'd7,
        OPC_BIT  = 4'd8
    } alu_opc_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_EXT  = 2'd2
    } cin_sel_e;

    typedef enum logic [1:0] {
        LOG_AND = 2'd0,
        LOG_OR  = 2'd1,
        LOG_XOR = 2'd2
    } log_sel_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        logic              valid;
        logic              is_arith;
        logic              invert_b;
        cin_sel_e          cin_sel;
        log_sel_e          log_sel;
        logic              wr_en;
        logic [FLAG_W-1:0] mask;
    } alu_ctrl_t;

endpackage

// File: rtl/bwalu_decode.sv
module bwalu_decode
    import bwalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_ctrl_t        ctrl_d
);

    always_comb begin
        ctrl_d          = '0;
        ctrl_d.cin_sel  = CIN_ZERO;
        ctrl_d.log_sel  = LOG_AND;
        ctrl_d.valid    = 1'b1;
        ctrl_d.wr_en    = 1'b1;
        ctrl_d.mask     = 4'b1111;
        case (opcode)
            OPC_ADD: begin
                ctrl_d.is_arith = 1'b1;
            end
            OPC_ADDC: begin
                ctrl_d.is_arith = 1'b1;
                ctrl_d.cin_sel  = CIN_EXT;
            end
            OPC_SUB: begin
                ctrl_d.is_arith = 1'b1;
                ctrl_d.invert_b = 1'b1;
                ctrl_d.cin_sel  = CIN_ONE;
            end
            OPC_SUBC: begin
                ctrl_d.is_arith = 1'b1;
                ctrl_d.invert_b = 1'b1;
                ctrl_d.cin_sel  = CIN_EXT;
            end
            OPC_CMP: begin
                ctrl_d.is_arith = 1'b1;
                ctrl_d.invert_b = 1'b1;
                ctrl_d.cin_sel  = CIN_ONE;
                ctrl_d.wr_en    = 1'b0;
            end
            OPC_AND: begin
                ctrl_d.log_sel  = LOG_AND;
            end
            OPC_OR: begin
                ctrl_d.log_sel  = LOG_OR;
                ctrl_d.mask     = 4'b0000;
            end
            OPC_XOR: begin
                ctrl_d.log_sel  = LOG_XOR;
            end
            OPC_BIT: begin
                ctrl_d.log_sel  = LOG_AND;
                ctrl_d.wr_en    = 1'b0;
            end
            default: begin
                ctrl_d.valid    = 1'b0;
                ctrl_d.wr_en    = 1'b0;
                ctrl_d.mask     = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/bwalu_adder.sv
module bwalu_adder #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              byte_mode,
    input  logic              invert_b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum_d,
    output logic              carry_d,
    output logic              ovf_d
);

    localparam int unsigned UPPER_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] a_m, b_m, b_x;
    logic [DATA_W:0]   total;
    logic              sa, sb, sr;

    always_comb begin
        b_x = invert_b ? ~b_i : b_i;
        a_m = byte_mode ? {{UPPER_W{1'b0}}, a_i[BYTE_W-1:0]} : a_i;
        b_m = byte_mode ? {{UPPER_W{1'b0}}, b_x[BYTE_W-1:0]} : b_x;
        total = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
        if (byte_mode) begin
            sum_d   = {{UPPER_W{1'b0}}, total[BYTE_W-1:0]};
            carry_d = total[BYTE_W];
            sa      = a_m[BYTE_W-1];
            sb      = b_m[BYTE_W-1];
            sr      = total[BYTE_W-1];
        end else begin
            sum_d   = total[DATA_W-1:0];
            carry_d = total[DATA_W];
            sa      = a_m[DATA_W-1];
            sb      = b_m[DATA_W-1];
            sr      = total[DATA_W-1];
        end
        ovf_d = (sa == sb) && (sr != sa);
    end

    // R1: adding two values whose selected top bits are both set must carry out
    always_comb begin
        if (!$isunknown({a_i, b_i, byte_mode, invert_b, cin}) && !invert_b) begin
            if (byte_mode && a_i[BYTE_W-1] && b_i[BYTE_W-1])
                a_r1_carry_on_two_msbs: assert (carry_d);
            if (!byte_mode && a_i[DATA_W-1] && b_i[DATA_W-1])
                a_r1_carry_on_two_msbs_w: assert (carry_d);
        end
    end

endmodule

// File: rtl/bwalu_logic.sv
module bwalu_logic
    import bwalu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              byte_mode,
    input  log_sel_e          log_sel,
    output logic [DATA_W-1:0] res_d
);

    localparam int unsigned UPPER_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] raw;

    always_comb begin
        case (log_sel)
            LOG_OR:  raw = a_i | b_i;
            LOG_XOR: raw = a_i ^ b_i;
            default: raw = a_i & b_i;
        endcase
        res_d = byte_mode ? {{UPPER_W{1'b0}}, raw[BYTE_W-1:0]} : raw;
    end

endmodule

// File: rtl/bwalu_flags.sv
module bwalu_flags
    import bwalu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              byte_mode,
    input  logic              is_arith,
    input  logic              carry_i,
    input  logic              ovf_i,
    output alu_flags_t        flags_d
);

    logic zero_w;

    always_comb begin
        zero_w    = byte_mode ? (res_i[BYTE_W-1:0] == '0) : (res_i == '0);
        flags_d.n = byte_mode ? res_i[BYTE_W-1] : res_i[DATA_W-1];
        flags_d.z = zero_w;
        flags_d.v = is_arith ? ovf_i   : 1'b0;
        flags_d.c = is_arith ? carry_i : !zero_w;
    end

    // R9: bitwise operations clear V and set C to the inverse of Z
    always_comb begin
        if (!$isunknown({res_i, byte_mode, is_arith}) && !is_arith) begin
            a_r9_logic_v_clear: assert (!flags_d.v);
            a_r9_logic_c_not_z: assert (flags_d.c != flags_d.z);
        end
    end

endmodule

// File: rtl/bwalu_top.sv
module bwalu_top
    import bwalu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic [3:0]  opcode,
    input  logic        byte_mode,
    input  logic        carry_in,
    output logic [15:0] result,
    output logic        flag_v,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_c,
    output logic [3:0]  flag_mask,
    output logic        wr_en
);

    alu_ctrl_t         ctrl_d;
    logic [DATA_W-1:0] sum_d, log_d, res_d;
    logic              carry_d, ovf_d, cin_d;
    alu_flags_t        flags_d;

    bwalu_decode u_decode (
        .opcode (opcode),
        .ctrl_d (ctrl_d)
    );

    always_comb begin
        case (ctrl_d.cin_sel)
            CIN_ONE: cin_d = 1'b1;
            CIN_EXT: cin_d = carry_in;
            default: cin_d = 1'b0;
        endcase
    end

    bwalu_adder #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_adder (
        .a_i       (op_a),
        .b_i       (op_b),
        .byte_mode (byte_mode),
        .invert_b  (ctrl_d.invert_b),
        .cin       (cin_d),
        .sum_d     (sum_d),
        .carry_d   (carry_d),
        .ovf_d     (ovf_d)
    );

    bwalu_logic #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_logic (
        .a_i       (op_a),
        .b_i       (op_b),
        .byte_mode (byte_mode),
        .log_sel   (ctrl_d.log_sel),
        .res_d     (log_d)
    );

    always_comb begin
        if (!ctrl_d.valid)       res_d = '0;
        else if (ctrl_d.is_arith) res_d = sum_d;
        else                      res_d = log_d;
    end

    bwalu_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flags (
        .res_i     (res_d),
        .byte_mode (byte_mode),
        .is_arith  (ctrl_d.is_arith),
        .carry_i   (carry_d),
        .ovf_i     (ovf_d),
        .flags_d   (flags_d)
    );

    always_comb begin
        result    = res_d;
        flag_v    = flags_d.v;
        flag_n    = flags_d.n;
        flag_z    = flags_d.z;
        flag_c    = flags_d.c;
        flag_mask = ctrl_d.mask;
        wr_en     = ctrl_d.wr_en;
    end

    always_comb begin
        if (!$isunknown({op_a, op_b, opcode, byte_mode, carry_in})) begin
            // R7: upper result byte is zero in byte mode
            if (byte_mode)
                a_r7_upper_byte_zero: assert (result[15:8] == 8'h00);
            // R8: compare never writes back
            if (opcode == OPC_CMP)
                a_r8_cmp_no_write: assert (!wr_en && flag_mask == 4'b1111);
            // R11: bit-test never writes back
            if (opcode == OPC_BIT)
                a_r11_bit_no_write: assert (!wr_en && flag_mask == 4'b1111);
            // R12: unused opcodes do nothing
            if (opcode > 4'd8)
                a_r12_unused_idle: assert (!wr_en && flag_mask == 4'b0000 && result == 16'h0000);
            // R10: OR loads no flags
            if (opcode == OPC_OR)
                a_r10_or_no_flags: assert (flag_mask == 4'b0000 && wr_en);
        end
    end

endmodule

// File: tb/bwalu_top_tb.sv
`timescale 1ns/1ps
module bwalu_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0, op_b = '0;
    logic [3:0]  opcode = '0;
    logic        byte_mode = 1'b0, carry_in = 1'b0;
    logic [15:0] result;
    logic        flag_v, flag_n, flag_z, flag_c, wr_en;
    logic [3:0]  flag_mask;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bwalu_top u_dut (
        .op_a(op_a), .op_b(op_b), .opcode(opcode), .byte_mode(byte_mode),
        .carry_in(carry_in), .result(result), .flag_v(flag_v), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_mask(flag_mask), .wr_en(wr_en)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // Reference derived from the requirements using integer arithmetic
    task automatic model(input int opc, input int a, input int b, input bit bm, input bit ci,
                         output int res, output bit v, output bit n, output bit z,
                         output bit c, output int msk, output bit we);
        int m    = bm ? 255 : 65535;
        int half = bm ? 128 : 32768;
        int ua = a & m;
        int ub = b & m;
        int sa = (ua >= half) ? ua - 2*half : ua;
        int sb = (ub >= half) ? ub - 2*half : ub;
        int raw, sres, cc;
        v = 0; c = 0; msk = 15; we = 1; res = 0;
        case (opc)
            0, 1: begin
                cc = (opc == 1) ? int'(ci) : 0;
                raw = ua + ub + cc; sres = sa + sb + cc;
                res = raw & m; c = raw > m; v = (sres < -half) || (sres >= half);
            end
            2, 3, 4: begin
                cc = (opc == 3) ? int'(ci) : 1;
                raw = ua + (m - ub) + cc; sres = sa - sb - 1 + cc;
                res = raw & m; c = raw > m; v = (sres < -half) || (sres >= half);
                we = (opc != 4);
            end
            5, 8: begin res = ua & ub; we = (opc == 5); end
            6:    begin res = ua | ub; msk = 0; end
            7:    begin res = ua ^ ub; end
            default: begin res = 0; msk = 0; we = 0; end
        endcase
        n = (res & half) != 0;
        z = (res == 0);
        if (opc >= 5) c = !z;
    endtask

    task automatic run(input string tag, input int opc, input int a, input int b,
                       input bit bm, input bit ci);
        int er, em; bit ev, en, ez, ec, ew;
        @(negedge clk);
        opcode = opc[3:0]; op_a = a[15:0]; op_b = b[15:0]; byte_mode = bm; carry_in = ci;
        #1;
        model(opc, a, b, bm, ci, er, ev, en, ez, ec, em, ew);
        chk({tag, " result"}, int'(result), er);
        chk({tag, " mask"}, int'(flag_mask), em);
        chk({tag, " wr_en"}, int'(wr_en), int'(ew));
        if (opc <= 8) begin
            chk({tag, " V"}, int'(flag_v), int'(ev));
            chk({tag, " N"}, int'(flag_n), int'(en));
            chk({tag, " Z"}, int'(flag_z), int'(ez));
            chk({tag, " C"}, int'(flag_c), int'(ec));
        end
    endtask

    task automatic test_idle();
        run("R1 R6 idle zero add", 0, 0, 0, 0, 0);
        chk("R6 idle Z literal", int'(flag_z), 1);
    endtask

    task automatic test_add();
        run("R1 R5 word 7fff+1", 0, 16'h7FFF, 1, 0, 0);
        chk("R5 word overflow literal", int'(flag_v), 1);
        run("R1 word carry ffff+1", 0, 16'hFFFF, 1, 0, 1);
        chk("R1 carry literal", int'(flag_c), 1);
        run("R1 R5 word neg+neg", 0, 16'h8000, 16'h8000, 0, 0);
    endtask

    task automatic test_addc();
        run("R2 addc cin=1", 1, 16'h1234, 16'h0001, 0, 1);
        chk("R2 addc literal", int'(result), 16'h1236);
        run("R2 addc cin=0", 1, 16'h1234, 16'h0001, 0, 0);
        run("R2 byte addc wrap", 1, 16'h00FE, 16'h0001, 1, 1);
    endtask

    task automatic test_sub();
        run("R3 equal operands", 2, 16'h5555, 16'h5555, 0, 0);
        chk("R3 no borrow C", int'(flag_c), 1);
        run("R3 a<b borrow", 2, 3, 5, 0, 1);
        chk("R3 borrow C literal", int'(flag_c), 0);
        run("R3 R5 sub overflow", 2, 16'h8000, 1, 0, 0);
    endtask

    task automatic test_subc();
        run("R4 subc cin=0", 3, 10, 3, 0, 0);
        chk("R4 subc literal", int'(result), 6);
        run("R4 subc cin=1", 3, 10, 3, 0, 1);
        run("R4 byte subc", 3, 16'hAA00, 16'h5501, 1, 0);
    endtask

    task automatic test_cmp();
        run("R8 cmp greater", 4, 9, 4, 0, 0);
        chk("R8 cmp wr_en literal", int'(wr_en), 0);
        run("R8 cmp equal byte", 4, 16'h1280, 16'h3480, 1, 0);
        run("R8 cmp overflow", 4, 16'h7FFF, 16'hFFFF, 0, 0);
    endtask

    task automatic test_byte();
        run("R7 byte carry under junk", 0, 16'hABFF, 16'h1201, 1, 0);
        chk("R7 byte result literal", int'(result), 0);
        chk("R7 byte carry literal", int'(flag_c), 1);
        run("R5 R7 byte 7f+1", 0, 16'hFF7F, 16'hFF01, 1, 0);
        chk("R5 byte overflow literal", int'(flag_v), 1);
        run("R6 R7 byte N bit7", 7, 16'h0F80, 16'hF000, 1, 0);
        chk("R6 byte N literal", int'(flag_n), 1);
    endtask

    task automatic test_logic();
        run("R9 and nonzero", 5, 16'hF0F0, 16'h3C3C, 0, 0);
        run("R9 and zero", 5, 16'hF0F0, 16'h0F0F, 0, 1);
        chk("R9 and C literal", int'(flag_c), 0);
        run("R9 xor", 7, 16'hFFFF, 16'h8001, 0, 0);
        run("R10 or", 6, 16'h00F0, 16'h0F00, 0, 0);
        chk("R10 or mask literal", int'(flag_mask), 0);
        run("R11 bit test", 8, 16'h8001, 16'h8000, 0, 0);
        chk("R11 bit wr_en literal", int'(wr_en), 0);
        run("R11 bit test byte zero", 8, 16'hFF00, 16'hFF00, 1, 0);
    endtask

    task automatic test_unused();
        for (int k = 9; k < 16; k++)
            run("R12 unused opcode", k, 16'hBEEF, 16'h1357, k[0], 1);
    endtask

    task automatic test_sweep();
        logic [31:0] lfsr = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run("R1 R5 R6 R7 sweep", int'(lfsr[3:0]) % 9, int'(lfsr[31:16]),
                int'(lfsr[15:0] ^ lfsr[27:12]), lfsr[4], lfsr[5]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_idle();
        test_add();
        test_addc();
        test_sub();
        test_subc();
        test_cmp();
        test_byte();
        test_logic();
        test_unused();
        test_sweep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule